// File: doc/BRIEF.md
# Serial Trace Control Wrapper

This block connects a signal-capture recorder to a serial line. A host sends a three-byte command over an 8N1 UART link. The command carries a 16-bit post-trigger sample count and a 3-bit configuration select. The two most significant bits of each byte say where it sits in the sequence. When the third byte has been received correctly, the wrapper does three things: it loads the count onto the recorder, it drives the select onto a configuration output, and it pulses an arm strobe.

After that the wrapper waits for the recorder to report that capture is complete. It then opens the recorder's read side and sends back every stored byte, without any request from the host, until the recorder reports that it has no more bytes.

The receiver and the transmitter share one tick generator. That generator produces a 16x oversampling tick from a divisor parameter. The configuration output is meant to switch between alternative trigger sources or signal routings around the recorder. The host can therefore look at different parts of a design without rebuilding it. All state is cleared by a synchronous active-low reset.

Top module: `uartdbg_wrap`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is cleared. After that edge, `uart_tx` is 1, `cfg_sel` and `rec_post_count` are 0, no strobe is pulsed, and the parser waits for a first byte.
- R2: The receiver decodes 8N1 frames, least significant bit first. One bit lasts 16*CLK_DIV clocks. A start bit is accepted only if the line stays low until half a bit time. A shorter low pulse produces no byte. A frame whose stop bit is sampled low is discarded.
- R3: The command has three bytes. The first byte has bits 7:6 = 00 and carries count[5:0] in bits 5:0. The second byte has bits 7:6 = 01 and carries count[11:6] in bits 5:0. The third byte has bit 7 = 1, carries cfg[2:0] in bits 6:4, and carries count[15:12] in bits 3:0.
- R4: Acceptance of a third byte loads `rec_post_count` and `cfg_sel` and pulses `rec_arm` high for exactly one cycle. At all other times these two outputs hold their values.
- R5: A byte that does not fit the expected position returns the parser to waiting for a first byte. A byte tagged 00 always starts a new command, discarding any partial one.
- R6: While armed, a high `rec_done` (ignored in the cycle of the arm pulse) starts readout. The block issues one `rec_rd_start` pulse and then transmits each `rec_rd_data` byte in order. It stops when `rec_rd_end` is high at the point where a byte would be loaded.
- R7: The transmitter sends 8N1 frames, least significant bit first, with the same bit period. `rec_rd_next` pulses exactly once per transmitted byte, and only after that byte's stop bit is complete.
- R8: A command completed during readout is discarded. `cfg_sel`, `rec_post_count` and `rec_arm` do not change, and the readout runs to its end.
- R9: `rec_done` has no effect while the block is not armed. No `rec_rd_start` pulse is issued and nothing is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uart_rx | input | 1 | Serial command input, idle high |
| uart_tx | output | 1 | Serial trace output, idle high |
| cfg_sel | output | 3 | Configuration select taken from the last accepted command |
| rec_arm | output | 1 | One-cycle pulse that starts a new capture |
| rec_post_count | output | 16 | Number of samples to record after the trigger |
| rec_done | input | 1 | Recorder has finished capture |
| rec_rd_start | output | 1 | One-cycle pulse that restarts the recorder read pointer |
| rec_rd_next | output | 1 | One-cycle pulse that advances the read pointer |
| rec_rd_data | input | 8 | Current trace byte, valid from the second cycle after a read pulse |
| rec_rd_end | input | 1 | The read pointer has passed the last trace byte |

## Verification
A received byte is reported near the middle of its stop bit. The parser adds one register and the sequencer adds one more, so the arm pulse and the new configuration appear a few clocks after that midpoint. The bench therefore samples them only after a full idle bit time has followed the stop bit.

Readout starts within two clocks of `rec_done`. Each trace byte then takes ten bit periods plus three clocks for the load and settle steps. The bench's serial monitor finds each start edge and samples each bit at its midpoint, 16*CLK_DIV clocks apart. Any drift in the bit period would corrupt the decoded bytes.

Conditions that must have no effect are checked after waiting several whole frame times. Over that wait the bench checks that no strobe was counted and no byte left the serial output.

// File: rtl/uartdbg_pkg.sv
package uartdbg_pkg;

    // Ticks per bit on both serial directions.
    localparam int OVERSAMPLE = 16;
    localparam int TICK_W     = $clog2(OVERSAMPLE);
    localparam int DATA_BITS  = 8;
    // Frame length including start and stop bits.
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int FRAME_W    = $clog2(FRAME_BITS);

    typedef logic [DATA_BITS-1:0] byte_t;

    typedef struct packed {
        logic [15:0] count;
        logic [2:0]  cfg;
    } dbg_cmd_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    typedef enum logic [1:0] {PS_FIRST, PS_SECOND, PS_THIRD} parse_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ARMED, SQ_OPEN, SQ_SETTLE, SQ_LOAD, SQ_SEND
    } seq_state_e;

    // Position tags in the top bits of a command byte.
    function automatic logic tag_first(byte_t b);
        return b[7:6] == 2'b00;
    endfunction

    function automatic logic tag_second(byte_t b);
        return b[7:6] == 2'b01;
    endfunction

    function automatic logic tag_third(byte_t b);
        return b[7];
    endfunction

endpackage

// File: rtl/uartdbg_tick.sv
module uartdbg_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/uartdbg_rx.sv
module uartdbg_rx
    import uartdbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  rx_pin,
    output byte_t rx_byte,
    output logic  rx_valid
);
    localparam logic [TICK_W-1:0] HALF = TICK_W'(OVERSAMPLE / 2 - 1);
    localparam logic [TICK_W-1:0] LAST = TICK_W'(OVERSAMPLE - 1);

    logic [2:0]        sync_q;
    logic              line;
    logic              fall;
    rx_state_e         state;
    logic [TICK_W-1:0] cnt;
    logic [2:0]        bitn;
    byte_t             shreg;

    assign line = sync_q[1];
    assign fall = sync_q[2] & ~sync_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '1;
            state    <= RX_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            sync_q   <= {sync_q[1:0], rx_pin};
            rx_valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (line) begin
                            state <= RX_IDLE;
                        end else if (cnt == HALF) begin
                            state <= RX_DATA;
                            cnt   <= '0;
                            bitn  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[7:1]};
                            if (bitn == 3'd7) begin
                                state <= RX_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            state <= RX_IDLE;
                            cnt   <= '0;
                            if (line) begin
                                rx_valid <= 1'b1;
                                rx_byte  <= shreg;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_rx_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state) == RX_STOP);

endmodule

// File: rtl/uartdbg_tx.sv
module uartdbg_tx
    import uartdbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  tx_start,
    input  byte_t tx_data,
    output logic  tx_pin,
    output logic  tx_busy,
    output logic  tx_done
);
    localparam logic [TICK_W-1:0]  LAST    = TICK_W'(OVERSAMPLE - 1);
    localparam logic [FRAME_W-1:0] LAST_BIT = FRAME_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame;
    logic [TICK_W-1:0]     cnt;
    logic [FRAME_W-1:0]    bitn;

    // Idle ones shift in behind the frame, so the line rests high.
    assign tx_pin = frame[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame   <= '1;
            cnt     <= '0;
            bitn    <= '0;
            tx_busy <= 1'b0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            if (!tx_busy) begin
                if (tx_start) begin
                    frame   <= {1'b1, tx_data, 1'b0};
                    cnt     <= '0;
                    bitn    <= '0;
                    tx_busy <= 1'b1;
                end
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    frame <= {1'b1, frame[FRAME_BITS-1:1]};
                    if (bitn == LAST_BIT) begin
                        tx_busy <= 1'b0;
                        tx_done <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_tx_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_busy);

    p_tx_line_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_pin);

endmodule

// File: rtl/uartdbg_cmd.sv
module uartdbg_cmd
    import uartdbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  byte_t    in_byte,
    input  logic     in_valid,
    output dbg_cmd_t cmd,
    output logic     cmd_valid
);
    parse_state_e pstate;
    logic [5:0]   lo6;
    logic [5:0]   mid6;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pstate    <= PS_FIRST;
            lo6       <= '0;
            mid6      <= '0;
            cmd       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (in_valid) begin
                if (tag_first(in_byte)) begin
                    lo6    <= in_byte[5:0];
                    pstate <= PS_SECOND;
                end else if (pstate == PS_SECOND && tag_second(in_byte)) begin
                    mid6   <= in_byte[5:0];
                    pstate <= PS_THIRD;
                end else if (pstate == PS_THIRD && tag_third(in_byte)) begin
                    cmd.count <= {in_byte[3:0], mid6, lo6};
                    cmd.cfg   <= in_byte[6:4];
                    cmd_valid <= 1'b1;
                    pstate    <= PS_FIRST;
                end else begin
                    pstate <= PS_FIRST;
                end
            end
        end
    end

    p_cmd_from_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(in_valid));

    p_cmd_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(pstate) == PS_THIRD);

endmodule

// File: rtl/uartdbg_wrap.sv
module uartdbg_wrap
    import uartdbg_pkg::*;
#(
    parameter int CLK_DIV = 50_000_000 / 16 / 115_200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uart_rx,
    output logic        uart_tx,
    output logic [2:0]  cfg_sel,
    output logic        rec_arm,
    output logic [15:0] rec_post_count,
    input  logic        rec_done,
    output logic        rec_rd_start,
    output logic        rec_rd_next,
    input  logic [7:0]  rec_rd_data,
    input  logic        rec_rd_end
);
    logic       tick;
    byte_t      rx_byte;
    logic       rx_valid;
    dbg_cmd_t   cmd;
    logic       cmd_valid;
    logic       tx_start;
    byte_t      tx_data;
    logic       tx_busy;
    logic       tx_done;
    seq_state_e seq;
    logic       accept;

    uartdbg_tick #(.DIV(CLK_DIV)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    uartdbg_rx rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_pin  (uart_rx),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid)
    );

    uartdbg_cmd cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (rx_byte),
        .in_valid (rx_valid),
        .cmd      (cmd),
        .cmd_valid(cmd_valid)
    );

    uartdbg_tx tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tx_start(tx_start),
        .tx_data (tx_data),
        .tx_pin  (uart_tx),
        .tx_busy (tx_busy),
        .tx_done (tx_done)
    );

    // Commands count only before readout begins.
    assign accept = cmd_valid && (seq == SQ_IDLE || seq == SQ_ARMED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq            <= SQ_IDLE;
            cfg_sel        <= '0;
            rec_post_count <= '0;
            rec_arm        <= 1'b0;
            rec_rd_start   <= 1'b0;
            rec_rd_next    <= 1'b0;
            tx_start       <= 1'b0;
            tx_data        <= '0;
        end else begin
            rec_arm      <= 1'b0;
            rec_rd_start <= 1'b0;
            rec_rd_next  <= 1'b0;
            tx_start     <= 1'b0;
            if (accept) begin
                cfg_sel        <= cmd.cfg;
                rec_post_count <= cmd.count;
                rec_arm        <= 1'b1;
                seq            <= SQ_ARMED;
            end else begin
                case (seq)
                    SQ_ARMED: begin
                        // A done flag left from the last capture is skipped
                        // while the arm pulse is still on its way.
                        if (rec_done && !rec_arm) begin
                            seq <= SQ_OPEN;
                        end
                    end
                    SQ_OPEN: begin
                        rec_rd_start <= 1'b1;
                        seq          <= SQ_SETTLE;
                    end
                    SQ_SETTLE: seq <= SQ_LOAD;
                    SQ_LOAD: begin
                        if (rec_rd_end) begin
                            seq <= SQ_IDLE;
                        end else begin
                            tx_data  <= rec_rd_data;
                            tx_start <= 1'b1;
                            seq      <= SQ_SEND;
                        end
                    end
                    SQ_SEND: begin
                        if (tx_done) begin
                            rec_rd_next <= 1'b1;
                            seq         <= SQ_SETTLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_arm_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_arm |=> !rec_arm);

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cfg_sel) && $stable(rec_post_count)));

    p_no_arm_readout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq inside {SQ_OPEN, SQ_SETTLE, SQ_LOAD, SQ_SEND}) |-> !rec_arm);

    p_next_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rd_next |-> !tx_busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SQ_IDLE && !cmd_valid) |=> !rec_rd_start);

    p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_arm, rec_rd_start, rec_rd_next}));

endmodule

// File: tb/uartdbg_wrap_tb_top.sv
module uartdbg_wrap_tb_top;

    localparam int DIV  = 4;
    localparam int BITC = 16 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uart_rx = 1'b1;
    logic        uart_tx;
    logic [2:0]  cfg_sel;
    logic        rec_arm;
    logic [15:0] rec_post_count;
    logic        rec_done = 1'b0;
    logic        rec_rd_start;
    logic        rec_rd_next;
    logic [7:0]  rec_rd_data;
    logic        rec_rd_end;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Bench recorder model.
    logic [7:0] mem [16];
    int         n_bytes = 0;
    int         rd_idx = 0;

    // Counters of observed strobes and monitored serial bytes.
    int         arm_cnt = 0;
    int         start_cnt = 0;
    int         next_cnt = 0;
    int         mon_cnt = 0;
    int         bad_stop = 0;
    logic [7:0] mon_log [16];

    always #4 clk = ~clk;

    uartdbg_wrap #(.CLK_DIV(DIV)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .uart_rx       (uart_rx),
        .uart_tx       (uart_tx),
        .cfg_sel       (cfg_sel),
        .rec_arm       (rec_arm),
        .rec_post_count(rec_post_count),
        .rec_done      (rec_done),
        .rec_rd_start  (rec_rd_start),
        .rec_rd_next   (rec_rd_next),
        .rec_rd_data   (rec_rd_data),
        .rec_rd_end    (rec_rd_end)
    );

    assign rec_rd_data = mem[rd_idx[3:0]];
    assign rec_rd_end  = rd_idx >= n_bytes;

    always @(posedge clk) begin
        if (rec_rd_start) rd_idx <= 0;
        else if (rec_rd_next) rd_idx <= rd_idx + 1;
    end

    always @(negedge clk) begin
        if (rec_arm) arm_cnt++;
        if (rec_rd_start) start_cnt++;
        if (rec_rd_next) next_cnt++;
    end

    // Serial monitor on uart_tx: start edge, then mid-bit samples.
    initial begin
        logic       prev;
        logic [7:0] b;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev && !uart_tx) begin
                repeat (BITC / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    b[i] = uart_tx;
                end
                repeat (BITC) @(negedge clk);
                if (!uart_tx) bad_stop++;
                mon_log[mon_cnt[3:0]] = b;
                mon_cnt++;
            end
            prev = uart_tx;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stop_ok = 1'b1);
        @(negedge clk);
        uart_rx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rx = b[i];
            repeat (BITC) @(negedge clk);
        end
        uart_rx = stop_ok;
        repeat (BITC) @(negedge clk);
        uart_rx = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    function automatic logic [7:0] cmd_b0(input logic [15:0] c);
        return {2'b00, c[5:0]};
    endfunction
    function automatic logic [7:0] cmd_b1(input logic [15:0] c);
        return {2'b01, c[11:6]};
    endfunction
    function automatic logic [7:0] cmd_b2(input logic [15:0] c, input logic [2:0] g);
        return {1'b1, g, c[15:12]};
    endfunction

    task automatic send_cmd(input logic [15:0] c, input logic [2:0] g);
        send_byte(cmd_b0(c));
        send_byte(cmd_b1(c));
        send_byte(cmd_b2(c, g));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(uart_tx === 1'b1, "R1 tx idle", int'(uart_tx), 1);
        check(cfg_sel === 3'd0, "R1 cfg", int'(cfg_sel), 0);
        check(rec_post_count === 16'd0, "R1 count", int'(rec_post_count), 0);
        check(arm_cnt == 0 && start_cnt == 0, "R1 strobes", arm_cnt + start_cnt, 0);
    endtask

    task automatic t_basic();
        int a0 = arm_cnt;
        send_cmd(16'hA5C3, 3'd5);
        check(arm_cnt == a0 + 1, "R4 one arm pulse", arm_cnt - a0, 1);
        check(rec_post_count === 16'hA5C3, "R3 count", int'(rec_post_count), 16'hA5C3);
        check(cfg_sel === 3'd5, "R3 cfg", int'(cfg_sel), 5);
    endtask

    task automatic t_out_of_seq();
        int a0 = arm_cnt;
        // Second and third bytes with no first byte.
        send_byte(cmd_b1(16'h1234));
        send_byte(cmd_b2(16'h1234, 3'd2));
        // First byte, then a third byte in the second slot, then the rest.
        send_byte(cmd_b0(16'h1234));
        send_byte(cmd_b2(16'h1234, 3'd2));
        send_byte(cmd_b1(16'h1234));
        send_byte(cmd_b2(16'h1234, 3'd2));
        check(arm_cnt == a0, "R5 no arm out of order", arm_cnt - a0, 0);
        check(cfg_sel === 3'd5 && rec_post_count === 16'hA5C3, "R5 outputs held",
              int'(rec_post_count), 16'hA5C3);
    endtask

    task automatic t_restart();
        int a0 = arm_cnt;
        send_byte(cmd_b0(16'h0FFF));
        send_byte(cmd_b0(16'h7E2A));
        send_byte(cmd_b1(16'h7E2A));
        send_byte(cmd_b2(16'h7E2A, 3'd1));
        check(arm_cnt == a0 + 1, "R5 restart arms", arm_cnt - a0, 1);
        check(rec_post_count === 16'h7E2A, "R5 restart uses newest first byte",
              int'(rec_post_count), 16'h7E2A);
    endtask

    task automatic t_frame_err();
        int a0 = arm_cnt;
        send_byte(cmd_b0(16'h0041), 1'b0);
        send_byte(cmd_b1(16'h0041));
        send_byte(cmd_b2(16'h0041, 3'd3));
        check(arm_cnt == a0, "R2 bad stop drops byte", arm_cnt - a0, 0);
    endtask

    task automatic t_glitch();
        int a0 = arm_cnt;
        send_byte(cmd_b0(16'hC00F));
        @(negedge clk);
        uart_rx = 1'b0;
        repeat (BITC / 4) @(negedge clk);
        uart_rx = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        send_byte(cmd_b1(16'hC00F));
        send_byte(cmd_b2(16'hC00F, 3'd6));
        check(arm_cnt == a0 + 1, "R2 short pulse ignored", arm_cnt - a0, 1);
        check(rec_post_count === 16'hC00F && cfg_sel === 3'd6, "R2 command intact",
              int'(rec_post_count), 16'hC00F);
    endtask

    task automatic wait_bytes(input int n);
        int guard = 0;
        while (mon_cnt < n && guard < 40 * BITC * (n + 1)) begin
            @(negedge clk);
            guard++;
        end
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic t_readout();
        logic [7:0] pat [4] = '{8'h3C, 8'h81, 8'h00, 8'hFE};
        int s0 = start_cnt;
        int n0 = next_cnt;
        for (int i = 0; i < 4; i++) mem[i] = pat[i];
        n_bytes = 4;
        mon_cnt = 0;
        bad_stop = 0;
        send_cmd(16'h0010, 3'd4);
        rec_done = 1'b1;
        wait_bytes(4);
        check(mon_cnt == 4, "R6 byte count", mon_cnt, 4);
        for (int i = 0; i < 4; i++)
            check(mon_log[i] === pat[i], "R7 byte value", int'(mon_log[i]), int'(pat[i]));
        check(start_cnt == s0 + 1, "R6 one read start", start_cnt - s0, 1);
        check(next_cnt == n0 + 4, "R7 one advance per byte", next_cnt - n0, 4);
        check(bad_stop == 0, "R7 stop bits high", bad_stop, 0);
    endtask

    task automatic t_done_idle();
        int s0 = start_cnt;
        mon_cnt = 0;
        rec_done = 1'b1;
        repeat (30 * BITC) @(negedge clk);
        check(start_cnt == s0, "R9 no read start while idle", start_cnt - s0, 0);
        check(mon_cnt == 0, "R9 nothing sent while idle", mon_cnt, 0);
    endtask

    task automatic t_cmd_in_readout();
        int a0;
        rec_done = 1'b0;
        for (int i = 0; i < 10; i++) mem[i] = 8'(8'h11 * i + 8'h07);
        n_bytes = 10;
        send_cmd(16'h2222, 3'd3);
        a0 = arm_cnt;
        mon_cnt = 0;
        bad_stop = 0;
        rec_done = 1'b1;
        while (mon_cnt < 1) @(negedge clk);
        send_cmd(16'h5555, 3'd6);
        wait_bytes(10);
        check(arm_cnt == a0, "R8 no arm during readout", arm_cnt - a0, 0);
        check(cfg_sel === 3'd3 && rec_post_count === 16'h2222, "R8 outputs held",
              int'(rec_post_count), 16'h2222);
        check(mon_cnt == 10 && mon_log[9] === 8'(8'h11 * 9 + 8'h07), "R8 readout complete",
              mon_cnt, 10);
        rec_done = 1'b0;
    endtask

    task automatic t_reset_clears();
        do_reset();
        check(cfg_sel === 3'd0 && rec_post_count === 16'd0, "R1 reset clears config",
              int'(cfg_sel), 0);
        check(uart_tx === 1'b1, "R1 reset idles line", int'(uart_tx), 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_out_of_seq();
        t_restart();
        t_frame_err();
        t_glitch();
        t_readout();
        t_done_idle();
        t_cmd_in_readout();
        t_reset_clears();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule